// File: doc/BRIEF.md
# Three-Mode Lookup Cell

This block is a single four-input lookup cell built around one 16-bit storage vector. A two-bit mode setting decides what that vector is. It can be a fixed truth table, a shift chain with a selectable output tap, or a one-bit-wide RAM with sixteen words. In every mode, the four select inputs choose the storage bit that appears on the output. That read path is a pure mux tree, with no register in it.

A load strobe copies a 16-bit parallel value into the storage in any mode. This is the only way to give the cell its truth table. The cell has plain control pins. It has no streaming data path, so there is no valid/ready handshake and no back-pressure. The clock edge either updates the storage or leaves it unchanged; the cell can never stall. An asynchronous active-low reset clears the storage.

Top module: `tri_mode_lut`

## Requirements
- R1: While `rst_n` is low, and after it is released with no other activity, all 16 storage bits are 0, so `dout` is 0 for every value of `sel`.
- R2: `dout` equals storage bit n, where n is the unsigned value of `sel`. It follows a change of `sel` in the same cycle, with no clock edge needed.
- R3: In logic mode (`mode` = 0) and in the spare code (`mode` = 3), the storage does not change on a clock edge when `load` is low, whatever `wr_en` and `din` are.
- R4: In shift mode (`mode` = 1), a clock edge with `wr_en` high and `load` low moves each bit n to bit n+1. Bit 0 takes `din`, and the old bit 15 is dropped.
- R5: In RAM mode (`mode` = 2), a clock edge with `wr_en` high and `load` low writes `din` into bit `sel` and leaves the other 15 bits unchanged. A read of that address shows the new value right after the edge.
- R6: A clock edge with `load` high sets storage bit n to `init_val[n]` in every mode. `load` takes priority over `wr_en`.
- R7: A clock edge with both `load` and `wr_en` low leaves the storage unchanged in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; storage updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears the storage |
| mode | input | 2 | 0 logic, 1 shift, 2 RAM, 3 treated as logic |
| sel | input | 4 | Read select; also the write address in RAM mode |
| din | input | 1 | Shift-in bit or RAM write data |
| wr_en | input | 1 | Shift enable in shift mode, write enable in RAM mode |
| load | input | 1 | Parallel load strobe; overrides `wr_en` |
| init_val | input | 16 | Parallel load value; bit n goes to storage bit n |
| dout | output | 1 | Storage bit selected by `sel` |

## Verification
After every clock edge, the bench reads back all sixteen storage bits by sweeping `sel` without a clock. A corrupted neighbouring bit or a wrong shift direction therefore shows up even when the probed tap looks correct. Several cases are driven on purpose:
- `wr_en` is held high in logic mode and in the spare mode code. A design that treated either code as a shift or a write would change its truth table.
- `load` and `wr_en` are asserted together in shift and RAM modes. A design with the wrong priority would shift or write instead of taking `init_val`.
- All sixteen RAM addresses are written with both data values. An address decoder that is off by one bit, or mirrored, would corrupt a neighbouring word.

// File: rtl/tml_pkg.sv
package tml_pkg;
  typedef enum logic [1:0] {
    MODE_LOGIC = 2'd0,
    MODE_SHIFT = 2'd1,
    MODE_RAM   = 2'd2,
    MODE_SPARE = 2'd3
  } tml_mode_e;
endpackage

// File: rtl/tml_next_state.sv
module tml_next_state
  import tml_pkg::*;
#(
  parameter int SEL_W = 4,
  localparam int DEPTH = 1 << SEL_W
) (
  input  logic [DEPTH-1:0] cur,
  input  tml_mode_e        mode,
  input  logic [SEL_W-1:0] sel,
  input  logic             din,
  input  logic             wr_en,
  input  logic             load,
  input  logic [DEPTH-1:0] init_val,
  output logic [DEPTH-1:0] nxt
);
  logic [DEPTH-1:0] wr_hit;

  for (genvar i = 0; i < DEPTH; i++) begin : g_dec
    assign wr_hit[i] = (sel == SEL_W'(i));
  end

  always_comb begin
    nxt = cur;
    if (load) begin
      nxt = init_val;
    end else if (wr_en) begin
      unique case (mode)
        MODE_SHIFT: nxt = {cur[DEPTH-2:0], din};
        MODE_RAM: begin
          for (int i = 0; i < DEPTH; i++) begin
            if (wr_hit[i]) nxt[i] = din;
          end
        end
        default: nxt = cur;
      endcase
    end
  end
endmodule

// File: rtl/tml_store.sv
module tml_store #(
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] nxt,
  output logic [DEPTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  // R1: reset leaves the storage empty
  always_comb begin
    if (!rst_n) assert_reset_clear_R1: assert (q == '0);
  end
endmodule

// File: rtl/tml_tap_mux.sv
module tml_tap_mux #(
  parameter int SEL_W = 4,
  localparam int DEPTH = 1 << SEL_W
) (
  input  logic [DEPTH-1:0] data,
  input  logic [SEL_W-1:0] sel,
  output logic             dout
);
  for (genvar l = 0; l <= SEL_W; l++) begin : g_lvl
    localparam int W = DEPTH >> l;
    logic [W-1:0] v;
    if (l == 0) begin : g_leaf
      assign v = data;
    end else begin : g_node
      for (genvar i = 0; i < W; i++) begin : g_pair
        assign v[i] = sel[l-1] ? g_lvl[l-1].v[2*i+1] : g_lvl[l-1].v[2*i];
      end
    end
  end

  assign dout = g_lvl[SEL_W].v[0];
endmodule

// File: rtl/tri_mode_lut.sv
module tri_mode_lut
  import tml_pkg::*;
#(
  parameter int SEL_W = 4,
  localparam int DEPTH = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [SEL_W-1:0] sel,
  input  logic             din,
  input  logic             wr_en,
  input  logic             load,
  input  logic [DEPTH-1:0] init_val,
  output logic             dout
);
  tml_mode_e        mode_e;
  logic [DEPTH-1:0] store_q;
  logic [DEPTH-1:0] store_d;

  assign mode_e = tml_mode_e'(mode);

  tml_next_state #(.SEL_W(SEL_W)) u_next (
    .cur(store_q), .mode(mode_e), .sel(sel), .din(din),
    .wr_en(wr_en), .load(load), .init_val(init_val), .nxt(store_d)
  );

  tml_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .nxt(store_d), .q(store_q)
  );

  tml_tap_mux #(.SEL_W(SEL_W)) u_mux (
    .data(store_q), .sel(sel), .dout(dout)
  );

  assert_logic_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && (mode_e == MODE_LOGIC || mode_e == MODE_SPARE)) |=> $stable(store_q));

  assert_shift_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && wr_en && mode_e == MODE_SHIFT) |=> (store_q[0] == $past(din)));

  assert_shift_move_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && wr_en && mode_e == MODE_SHIFT)
      |=> (store_q[DEPTH-1:1] == $past(store_q[DEPTH-2:0])));

  assert_ram_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && wr_en && mode_e == MODE_RAM) |=> (store_q[$past(sel)] == $past(din)));

  assert_ram_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && wr_en && mode_e == MODE_RAM) |=> ($countones(store_q ^ $past(store_q)) <= 1));

  assert_load_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (store_q == $past(init_val)));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !wr_en) |=> $stable(store_q));
endmodule

// File: tb/tri_mode_lut_bench.sv
module tri_mode_lut_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [3:0]  sel = 4'd0;
  logic        din = 1'b0;
  logic        wr_en = 1'b0;
  logic        load = 1'b0;
  logic [15:0] init_val = 16'h0;
  logic        dout;

  int          n_run = 0;
  int          n_fail = 0;
  logic [15:0] exp_q = 16'h0;
  string       tag = "R1";
  bit          done = 1'b0;

  always #5 clk = ~clk;

  tri_mode_lut u_tri_mode_lut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .sel(sel), .din(din),
    .wr_en(wr_en), .load(load), .init_val(init_val), .dout(dout)
  );

  // Read every address without a clock edge (R2) and compare with the model.
  task automatic sweep();
    for (int a = 0; a < 16; a++) begin
      sel = 4'(a);
      #1;
      n_run++;
      if (dout !== exp_q[a]) begin
        n_fail++;
        $display("FAIL %s addr %0d: dout=%b expected %b", tag, a, dout, exp_q[a]);
      end
    end
  endtask

  // One clock edge with the given stimulus, then update the model.
  task automatic step(input logic [1:0] m, input logic [3:0] s, input logic d,
                      input logic w, input logic ld, input logic [15:0] iv);
    @(negedge clk);
    mode = m; sel = s; din = d; wr_en = w; load = ld; init_val = iv;
    if (ld)                   tag = "R6";
    else if (!w)              tag = "R7";
    else if (m == 2'd1)       tag = "R4";
    else if (m == 2'd2)       tag = "R5";
    else                      tag = "R3";
    @(posedge clk);
    #1;
    wr_en = 1'b0; load = 1'b0;
    if (ld) exp_q = iv;
    else if (w && m == 2'd1) exp_q = {exp_q[14:0], d};
    else if (w && m == 2'd2) exp_q[s] = d;
    sweep();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    sweep();                       // R1 while reset is held
    rst_n = 1'b1;
    @(posedge clk); #1;
    sweep();                       // R1 after release

    // R2: loaded pattern read back by address
    step(2'd0, 4'd0, 1'b0, 1'b0, 1'b1, 16'hA5C3);
    tag = "R2";
    sweep();

    // R3: logic mode and spare code ignore wr_en and din
    for (int k = 0; k < 40; k++)
      step(2'd0, 4'($urandom), 1'($urandom), 1'b1, 1'b0, 16'h0);
    for (int k = 0; k < 20; k++)
      step(2'd3, 4'($urandom), 1'($urandom), 1'($urandom), 1'b0, 16'h0);

    // R6: load overrides a shift request
    step(2'd1, 4'd0, 1'b1, 1'b1, 1'b1, 16'h1E69);

    // R4 / R7: random shift sequence
    for (int k = 0; k < 200; k++)
      step(2'd1, 4'($urandom), 1'($urandom), 1'($urandom), 1'b0, 16'h0);

    // R5: every RAM address with both data values
    for (int d = 0; d < 2; d++)
      for (int a = 0; a < 16; a++)
        step(2'd2, 4'(a), d[0] ^ a[0], 1'b1, 1'b0, 16'h0);
    for (int k = 0; k < 200; k++)
      step(2'd2, 4'($urandom), 1'($urandom), 1'($urandom), 1'b0, 16'h0);

    // R6: load overrides a RAM write, and loads in logic mode
    step(2'd2, 4'd5, 1'b1, 1'b1, 1'b1, 16'h8001);
    step(2'd0, 4'd0, 1'b0, 1'b1, 1'b1, 16'h7FFE);

    // R7: idle edges in all modes, mixed with random loads
    for (int k = 0; k < 60; k++)
      step(2'($urandom), 4'($urandom), 1'($urandom), 1'b0,
           (k % 7 == 0), 16'($urandom));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule